// File: doc/BRIEF.md
# Addressed Serial Settings Register Bank

This block takes control words over a three-wire serial link (an active-low enable strobe, a serial clock and serial data) and turns them into parallel setting buses for a camera front end. Each word is twelve bits long. Two address bits pick one of four setting groups and ten payload bits carry the value. The groups are an amplifier gain code, a control-DAC code, a converter clamp level and a set of control-pulse polarity flags.

All inputs are asynchronous to the block clock. They pass through synchronizers, and their edges are detected in the clock domain. A word is accepted into a holding register on the rising edge of the enable, and only if exactly twelve bits were clocked in. The DAC code drives its output straight from its holding register. The gain, clamp and polarity groups reach their outputs only through a second, active stage. That stage copies the holding registers on a frame-sync edge, and the direction of that edge is itself a polarity setting. When a system has no frame sync, the enable strobe can be wired to the sync input.

Top module: `serial_ctrl_bank`

## Requirements
- R1: A word is captured most significant bit first, one bit on each rising serial-clock edge while the enable is low: address bit 1, address bit 0, then payload bits 9 down to 0.
- R2: On the rising edge of the enable, the holding register named by the address loads only if exactly 12 bits were shifted since the enable fell. With 11 or 13 bits, every register and every output keeps its value.
- R3: Address 00 writes the gain code from payload bits 8..0. Payload bit 9 is ignored.
- R4: Address 01 writes the DAC code from payload bits 7..0, and it appears on the output without any sync edge. Payload bits 9..8 are ignored.
- R5: Address 10 writes the clamp code from payload bits 6..0. Payload bits 9..7 are ignored.
- R6: Address 11 writes the polarity flags, where 1 means active high. Payload bit 0 is the sample pulses, bit 1 the data clock, bit 3 the optical-black clamp, bit 5 blanking and bit 6 the sync edge (0 rising, 1 falling). The dummy-clamp flag always reads 0, and bits 2 and 4 have no effect.
- R7: The gain, clamp and polarity outputs change only on the selected frame-sync edge. On that edge each output takes the value held in its holding register.
- R8: The sync edge direction follows polarity bit 6 as soon as a polarity word is accepted, before that word reaches the active stage.
- R9: After reset the gain, DAC and clamp codes are 0. The sample, clock, optical-black and blanking flags are 1, the dummy-clamp flag is 0, and the sync edge is rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serEn | input | 1 | Serial enable strobe, low during a word |
| serClk | input | 1 | Serial bit clock |
| serData | input | 1 | Serial data |
| frameSync | input | 1 | Frame sync used to apply settings |
| gainCode | output | 9 | Active amplifier gain code |
| dacCode | output | 8 | Control-DAC code |
| clampCode | output | 7 | Active converter clamp code |
| samplePolHigh | output | 1 | Sample pulses active high |
| clockPolHigh | output | 1 | Data clock active high |
| dummyClampPolHigh | output | 1 | Dummy clamp active high, always 0 |
| obClampPolHigh | output | 1 | Optical-black clamp active high |
| blankPolHigh | output | 1 | Blanking active high |
| syncFallSel | output | 1 | Active sync edge is falling |

## Verification
Each input first crosses two synchronizer stages and then an edge-detect register. So a change on an input pin reaches a register output on the third rising clock edge after it is driven. This holds for a serial-clock edge shifting a bit, for the enable rising to load a holding register (which makes the DAC output change), and for a sync edge updating the active stage. The bench changes inputs only on falling clock edges and holds each serial phase for four cycles. After an enable rise or a sync change it waits six cycles before sampling on a falling edge. Each gain, clamp and polarity write is checked twice: once after the enable rise, where the old value must still be showing, and once after the sync edge, where the new value must appear.

// File: rtl/serial_ctrl_pkg.sv
package serial_ctrl_pkg;

  localparam int NUM_GROUPS = 4;

  typedef enum logic [1:0] {
    GRP_GAIN  = 2'b00,
    GRP_DAC   = 2'b01,
    GRP_CLAMP = 2'b10,
    GRP_POL   = 2'b11
  } grpSel_e;

  // payload bit positions of the polarity word (decoded by the pulse generators)
  localparam int POL_BIT_SAMPLE = 0;
  localparam int POL_BIT_CLOCK  = 1;
  localparam int POL_BIT_OBCLMP = 3;
  localparam int POL_BIT_BLANK  = 5;
  localparam int POL_BIT_EDGE   = 6;

  typedef struct packed {
    logic syncFall;
    logic blank;
    logic obClamp;
    logic clock;
    logic sample;
  } polSet_t;

  localparam polSet_t POL_RESET = '{syncFall: 1'b0, blank: 1'b1, obClamp: 1'b1,
                                    clock: 1'b1, sample: 1'b1};

  typedef struct packed {
    logic                  shift;
    logic [NUM_GROUPS-1:0] load;
    logic                  transfer;
  } ctrlStrb_t;

endpackage

// File: rtl/serial_ctrl_sync.sv
module serial_ctrl_sync #(
  parameter int          STAGES = 2,
  parameter int          WIDTH  = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= asyncIn;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/serial_ctrl_fsm.sv
module serial_ctrl_fsm
  import serial_ctrl_pkg::*;
#(
  parameter int FRAME_BITS = 12,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enS,
  input  logic              sclkS,
  input  logic              syncS,
  input  logic              edgeFallSel,
  input  logic [ADDR_W-1:0] frameAddr,
  output ctrlStrb_t         strb
);

  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_SAT = FRAME_BITS + 1;

  logic enPrev, sclkPrev, syncPrev;
  logic enRise, enFall, sclkRise, syncRise, syncFall;
  logic [CNT_W-1:0] bitCnt;
  logic frameOk;
  logic [NUM_GROUPS-1:0] loadVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      enPrev   <= enS;
      sclkPrev <= sclkS;
      syncPrev <= syncS;
    end
  end

  assign enRise   = enS & ~enPrev;
  assign enFall   = ~enS & enPrev;
  assign sclkRise = sclkS & ~sclkPrev;
  assign syncRise = syncS & ~syncPrev;
  assign syncFall = ~syncS & syncPrev;

  // bit counter: restarts when a word opens, saturates past a full word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (enFall) bitCnt <= '0;
    else if (sclkRise && !enS && bitCnt != CNT_W'(CNT_SAT)) bitCnt <= bitCnt + 1'b1;
  end

  assign frameOk = enRise && (bitCnt == CNT_W'(FRAME_BITS));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_decode
    assign loadVec[g] = frameOk && (frameAddr == ADDR_W'(g));
  end

  always_comb begin
    strb.shift    = sclkRise & ~enS;
    strb.load     = loadVec;
    strb.transfer = edgeFallSel ? syncFall : syncRise;
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.load)); // R2

  AST_NO_SHIFT_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.load) |-> !strb.shift); // R1

endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import serial_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 10,
  parameter int GAIN_W  = 9,
  parameter int DAC_W   = 8,
  parameter int CLAMP_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataS,
  input  ctrlStrb_t         strb,
  output logic [ADDR_W-1:0] frameAddr,
  output logic              edgeFallSel,
  output logic [GAIN_W-1:0] gainOut,
  output logic [DAC_W-1:0]  dacOut,
  output logic [CLAMP_W-1:0] clampOut,
  output polSet_t           polOut
);

  localparam int FRAME_BITS = ADDR_W + DATA_W;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [DATA_W-1:0]     payload;
  logic [GAIN_W-1:0]     gainHold, gainAct;
  logic [CLAMP_W-1:0]    clampHold, clampAct;
  logic [DAC_W-1:0]      dacHold;
  polSet_t               polHold, polAct, polNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], dataS};
  end

  assign frameAddr = shiftReg[FRAME_BITS-1 -: ADDR_W];
  assign payload   = shiftReg[DATA_W-1:0];

  always_comb begin
    polNext.sample   = payload[POL_BIT_SAMPLE];
    polNext.clock    = payload[POL_BIT_CLOCK];
    polNext.obClamp  = payload[POL_BIT_OBCLMP];
    polNext.blank    = payload[POL_BIT_BLANK];
    polNext.syncFall = payload[POL_BIT_EDGE];
  end

  // holding stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainHold  <= '0;
      dacHold   <= '0;
      clampHold <= '0;
      polHold   <= POL_RESET;
    end else begin
      if (strb.load[GRP_GAIN])  gainHold  <= payload[GAIN_W-1:0];
      if (strb.load[GRP_DAC])   dacHold   <= payload[DAC_W-1:0];
      if (strb.load[GRP_CLAMP]) clampHold <= payload[CLAMP_W-1:0];
      if (strb.load[GRP_POL])   polHold   <= polNext;
    end
  end

  // active stage, moved on the selected sync edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainAct  <= '0;
      clampAct <= '0;
      polAct   <= POL_RESET;
    end else if (strb.transfer) begin
      gainAct  <= gainHold;
      clampAct <= clampHold;
      polAct   <= polHold;
    end
  end

  assign edgeFallSel = polHold.syncFall;
  assign gainOut     = gainAct;
  assign dacOut      = dacHold;
  assign clampOut    = clampAct;
  assign polOut      = polAct;

  AST_DAC_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    strb.load[GRP_DAC] |=> dacOut == $past(payload[DAC_W-1:0])); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(|strb.load) |=> $stable(gainHold) && $stable(clampHold) && $stable(polHold)
                      && $stable(dacOut)); // R2

  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.transfer |=> $stable(gainOut) && $stable(clampOut) && $stable(polOut)); // R7

  AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.transfer |=> gainOut == $past(gainHold) && clampOut == $past(clampHold)
                      && polOut == $past(polHold)); // R7

endmodule

// File: rtl/serial_ctrl_bank.sv
module serial_ctrl_bank
  import serial_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 10,
  parameter int GAIN_W      = 9,
  parameter int DAC_W       = 8,
  parameter int CLAMP_W     = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serEn,
  input  logic               serClk,
  input  logic               serData,
  input  logic               frameSync,
  output logic [GAIN_W-1:0]  gainCode,
  output logic [DAC_W-1:0]   dacCode,
  output logic [CLAMP_W-1:0] clampCode,
  output logic               samplePolHigh,
  output logic               clockPolHigh,
  output logic               dummyClampPolHigh,
  output logic               obClampPolHigh,
  output logic               blankPolHigh,
  output logic               syncFallSel
);

  localparam int FRAME_BITS = ADDR_W + DATA_W;

  logic [3:0]        syncedIn;
  logic              enS, sclkS, dataS, syncS;
  logic [ADDR_W-1:0] frameAddr;
  logic              edgeFallSel;
  ctrlStrb_t         strb;
  polSet_t           polOut;

  serial_ctrl_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (4),
    .RST_VAL(4'b0001)
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({frameSync, serData, serClk, serEn}),
    .syncOut(syncedIn)
  );

  assign {syncS, dataS, sclkS, enS} = syncedIn;

  serial_ctrl_fsm #(
    .FRAME_BITS(FRAME_BITS),
    .ADDR_W    (ADDR_W)
  ) i_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .enS        (enS),
    .sclkS      (sclkS),
    .syncS      (syncS),
    .edgeFallSel(edgeFallSel),
    .frameAddr  (frameAddr),
    .strb       (strb)
  );

  serial_ctrl_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W),
    .DAC_W  (DAC_W),
    .CLAMP_W(CLAMP_W)
  ) i_regs (
    .clk        (clk),
    .rstN       (rstN),
    .dataS      (dataS),
    .strb       (strb),
    .frameAddr  (frameAddr),
    .edgeFallSel(edgeFallSel),
    .gainOut    (gainCode),
    .dacOut     (dacCode),
    .clampOut   (clampCode),
    .polOut     (polOut)
  );

  assign samplePolHigh     = polOut.sample;
  assign clockPolHigh      = polOut.clock;
  assign dummyClampPolHigh = 1'b0;
  assign obClampPolHigh    = polOut.obClamp;
  assign blankPolHigh      = polOut.blank;
  assign syncFallSel       = polOut.syncFall;

endmodule

// File: tb/test_serial_ctrl_bank.sv
module test_serial_ctrl_bank;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b1;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic frameSync = 1'b0;
  logic [8:0] gainCode;
  logic [7:0] dacCode;
  logic [6:0] clampCode;
  logic samplePolHigh, clockPolHigh, dummyClampPolHigh, obClampPolHigh, blankPolHigh, syncFallSel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_ctrl_bank i_serial_ctrl_bank (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk), .serData(serData),
    .frameSync(frameSync), .gainCode(gainCode), .dacCode(dacCode), .clampCode(clampCode),
    .samplePolHigh(samplePolHigh), .clockPolHigh(clockPolHigh),
    .dummyClampPolHigh(dummyClampPolHigh), .obClampPolHigh(obClampPolHigh),
    .blankPolHigh(blankPolHigh), .syncFallSel(syncFallSel)
  );

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // polarity flags packed as {syncFall, blank, obClamp, dummy, clock, sample}
  function automatic int polWord();
    return {26'd0, syncFallSel, blankPolHigh, obClampPolHigh, dummyClampPolHigh,
            clockPolHigh, samplePolHigh};
  endfunction

  // sends the first nBits of {addr,data}, MSB first; bits past 12 are zeros
  task automatic sendWord(input logic [1:0] addr, input logic [9:0] data, input int nBits);
    logic [11:0] word;
    word = {addr, data};
    serEn = 1'b0;
    waitCyc(4);
    for (int b = 0; b < nBits; b++) begin
      serData = (b < 12) ? word[11-b] : 1'b0;
      waitCyc(4);
      serClk = 1'b1;
      waitCyc(4);
      serClk = 1'b0;
    end
    waitCyc(4);
    serEn = 1'b1;
    waitCyc(6);
  endtask

  task automatic setSync(input logic v);
    frameSync = v;
    waitCyc(6);
  endtask

  task automatic testReset();
    check("R9", "gain reset", gainCode, 0);
    check("R9", "dac reset", dacCode, 0);
    check("R9", "clamp reset", clampCode, 0);
    check("R9", "polarity reset", polWord(), 6'b011011);
  endtask

  task automatic testGain();
    sendWord(2'b00, 10'h37F, 12);          // bit 9 set, must be ignored
    check("R7", "gain before sync", gainCode, 0);
    setSync(1'b1);
    check("R3", "gain after rising sync", gainCode, 9'h17F);
    setSync(1'b0);
    check("R7", "gain after falling sync", gainCode, 9'h17F);
  endtask

  task automatic testDac();
    sendWord(2'b01, 10'h3A5, 12);
    check("R4", "dac without sync", dacCode, 8'hA5);
  endtask

  task automatic testClamp();
    sendWord(2'b10, 10'h3D5, 12);
    check("R7", "clamp before sync", clampCode, 0);
    setSync(1'b1);
    check("R5", "clamp after sync", clampCode, 7'h55);
    setSync(1'b0);
  endtask

  task automatic testBadLength();
    sendWord(2'b00, 10'h0AA, 11);
    sendWord(2'b01, 10'h033, 13);
    check("R2", "dac after 13-bit word", dacCode, 8'hA5);
    setSync(1'b1);
    check("R2", "gain after 11-bit word", gainCode, 9'h17F);
    check("R2", "clamp after bad words", clampCode, 7'h55);
    setSync(1'b0);
  endtask

  task automatic testPolarity();
    sendWord(2'b11, 10'h016, 12);          // clock=1, bits 2 and 4 set, rest 0
    check("R7", "polarity before sync", polWord(), 6'b011011);
    setSync(1'b1);
    check("R6", "polarity after sync", polWord(), 6'b000010);
    setSync(1'b0);
  endtask

  task automatic testEdgeSelect();
    sendWord(2'b11, 10'h06B, 12);          // falling edge, all flags high
    sendWord(2'b00, 10'h064, 12);
    setSync(1'b1);
    check("R8", "gain unchanged on rising edge", gainCode, 9'h17F);
    check("R8", "polarity unchanged on rising edge", polWord(), 6'b000010);
    setSync(1'b0);
    check("R8", "gain on falling edge", gainCode, 9'h064);
    check("R6", "polarity on falling edge", polWord(), 6'b111011);
  endtask

  task automatic testSerialOrder();
    sendWord(2'b01, 10'h0C3, 12);          // asymmetric pattern, catches bit order
    check("R1", "dac msb-first order", dacCode, 8'hC3);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(4);
    testReset();
    testGain();
    testDac();
    testClamp();
    testBadLength();
    testPolarity();
    testEdgeSelect();
    testSerialOrder();
    finishRun();
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule